// File: doc/BRIEF.md
# Data Address Map Translator

This block turns a logical data offset into a physical address through four 16-bit map entries. The logical space is cut into four blocks of 0x4000 bytes, and the entry picked by the block number decides where that block lands. It can land in unified memory, instruction memory, internal data memory, or an I/O area. In the I/O area each 4 KB sub-window of the block is steered to its own 64 KB page. Each translation also returns a byte count, trimmed so that the access stays inside its block, and an error flag for offsets that cannot be mapped.

The map entries live in a small register file that appears in on-chip data segment 0. The entries sit at consecutive halfword offsets starting at 0xFF08. A second offset, 0xFF04, reaches entry 2 as well. A translation request is taken on a clock edge, and its result is presented one cycle later.

Top module: `dmap_xlate`

## Requirements
- R1: After reset, reading offsets 0xFF08, 0xFF0A, 0xFF0C and 0xFF0E returns 0x2000, 0x2000, 0x2000 and 0x0000, with cfg_rhit high.
- R2: Map entry n answers at data offset 0xFF08+2n. A write is visible on the combinational read port only after the clock edge that takes it. Writes to any other offset (for example 0xFF06 or the odd 0xFF09) change no entry. A read of an offset that is not a map entry gives cfg_rhit low and cfg_rdata 0.
- R3: Offset 0xFF04 is an alias of entry 2, for both reads and writes.
- R4: xl_vld is high exactly in the cycle after a cycle with xl_req high. The result uses the map contents as they were in the request cycle, so a write in that same cycle is not seen. Between requests, the result fields hold their values.
- R5: A logical offset at or above 0x10000 (four blocks) gives xl_err=1, xl_phys=0 and xl_cnt=0.
- R6: The block index is offset[15:14] and the in-block offset is offset[13:0]. When map bit 15 is 0, bits 13:12 select the space and bits 9:0 give the segment. Space 00 gives unified memory: phys = 0x00000000 + segment*0x4000 + in-block offset.
- R7: Space 01 gives instruction memory: phys = 0x01000000 + segment*0x4000 + in-block offset.
- R8: Space 10 gives data memory: phys = 0x02000000 + (segment<<16) + index*0x4000 + in-block offset. Map bits 11:10 are ignored.
- R9: Space 11 is reserved: xl_err=1, with phys and count 0.
- R10: When map bit 15 is 1 (I/O mode), let w = in-block offset[13:12]. The page is the map nibble at bits 4*(3-w)+3 : 4*(3-w), and phys = 0x02000000 + page*0x10000 + 0xC000 + in-block offset.
- R11: xl_cnt = min(xl_len, 0x4000 - in-block offset) for any mapped access.
- R12: In I/O mode, map bits 13:12 are ignored. A value of 11 there does not raise an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_waddr | input | 16 | Data offset of the write |
| cfg_wdata | input | 16 | Write value |
| cfg_raddr | input | 16 | Data offset of the combinational read |
| cfg_rdata | output | 16 | Read value, 0 on a miss |
| cfg_rhit | output | 1 | Read offset selects a map entry |
| xl_req | input | 1 | Translation request |
| xl_off | input | 20 | Logical data offset |
| xl_len | input | 16 | Requested byte count |
| xl_vld | output | 1 | Result valid, one cycle after the request |
| xl_err | output | 1 | Offset out of range or reserved space |
| xl_phys | output | 32 | Physical address |
| xl_cnt | output | 16 | Byte count trimmed to the block end |

## Verification
A wrong map entry shows up at once on the read port, and in the next translation result that uses the block. A mis-selected nibble or space shows up in the upper bits of xl_phys. A bad trim shows up when xl_phys[13:0] plus xl_cnt passes 0x4000. The result register is checked one cycle after each request. Reads are sampled in the same cycle as writes to show that a write lands exactly one edge later. Two cases probe the wrong-cycle error directly: a translation launched alongside a write, and the alias offset.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
    localparam int NUM_MAPS = 4;
    localparam int MAP_W    = 16;
    localparam int IDX_W    = $clog2(NUM_MAPS);

    typedef enum logic [1:0] {
        SP_UNIF = 2'b00,
        SP_INSN = 2'b01,
        SP_DATA = 2'b10,
        SP_RSVD = 2'b11
    } space_e;

    typedef logic [NUM_MAPS-1:0][MAP_W-1:0] map_arr_t;

    localparam map_arr_t MAP_RST = {16'h0000, 16'h2000, 16'h2000, 16'h2000};
endpackage

// File: rtl/dmap_regfile.sv
module dmap_regfile
    import dmap_pkg::*;
#(
    parameter logic [15:0] REG_BASE   = 16'hFF08,
    parameter logic [15:0] SHADOW_OFF = 16'hFF04,
    parameter int          SHADOW_IDX = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] waddr,
    input  logic [15:0] wdata,
    input  logic [15:0] raddr,
    output logic [15:0] rdata,
    output logic        rhit,
    output map_arr_t    maps
);
    typedef struct packed {
        map_arr_t map;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_MAPS-1:0] whit, rsel;

    for (genvar n = 0; n < NUM_MAPS; n++) begin : g_dec
        localparam logic [15:0] ADDR_N = REG_BASE + 16'(2 * n);
        if (n == SHADOW_IDX) begin : g_alias
            assign whit[n] = (waddr == ADDR_N) || (waddr == SHADOW_OFF);
            assign rsel[n] = (raddr == ADDR_N) || (raddr == SHADOW_OFF);
        end else begin : g_plain
            assign whit[n] = (waddr == ADDR_N);
            assign rsel[n] = (raddr == ADDR_N);
        end
    end

    always_comb begin
        regs_d = regs_q;
        for (int n = 0; n < NUM_MAPS; n++) begin
            if (we && whit[n]) regs_d.map[n] = wdata;
        end
        rdata = '0;
        for (int n = 0; n < NUM_MAPS; n++) begin
            if (rsel[n]) rdata = rdata | regs_q.map[n];
        end
        rhit = |rsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{map: MAP_RST};
        else        regs_q <= regs_d;
    end

    assign maps = regs_q.map;
endmodule

// File: rtl/dmap_calc.sv
module dmap_calc
    import dmap_pkg::*;
#(
    parameter int              LOFF_W      = 20,
    parameter int              LEN_W       = 16,
    parameter int              PA_W        = 32,
    parameter int              BLK_LOG2    = 14,
    parameter int              IOWIN_LOG2  = 12,
    parameter logic [PA_W-1:0] UNIF_BASE   = 32'h0000_0000,
    parameter logic [PA_W-1:0] INSN_BASE   = 32'h0100_0000,
    parameter logic [PA_W-1:0] DATA_BASE   = 32'h0200_0000,
    parameter logic [PA_W-1:0] IO_WIN_OFF  = 32'h0000_C000
) (
    input  map_arr_t          maps,
    input  logic [LOFF_W-1:0] off,
    input  logic [LEN_W-1:0]  len,
    output logic              err,
    output logic [PA_W-1:0]   phys,
    output logic [LEN_W-1:0]  cnt
);
    localparam int BLK = 1 << BLK_LOG2;
    localparam logic [LOFF_W-1:0] LIMIT = LOFF_W'(NUM_MAPS * BLK);

    logic                 in_range;
    logic [IDX_W-1:0]     idx;
    logic [BLK_LOG2-1:0]  in_off;
    logic [MAP_W-1:0]     map;
    logic                 io_mode;
    space_e               space;
    logic [9:0]           seg;
    logic [1:0]           win, nib_sel;
    logic [3:0]           page;
    logic [BLK_LOG2:0]    room;
    logic [LEN_W-1:0]     room_ext, clip;
    logic [PA_W-1:0]      seg_ext, off_ext;

    always_comb begin
        in_range = (off < LIMIT);
        idx      = off[BLK_LOG2 +: IDX_W];
        in_off   = off[BLK_LOG2-1:0];
        map      = maps[idx];
        io_mode  = map[15];
        space    = space_e'(map[13:12]);
        seg      = map[9:0];
        win      = in_off[IOWIN_LOG2 +: 2];
        nib_sel  = 2'd3 - win;
        page     = map[{nib_sel, 2'b00} +: 4];
        room     = (BLK_LOG2+1)'(BLK) - {1'b0, in_off};
        room_ext = LEN_W'(room);
        clip     = (len > room_ext) ? room_ext : len;
        seg_ext  = PA_W'(seg);
        off_ext  = PA_W'(in_off);

        err  = 1'b0;
        phys = '0;
        if (!in_range) begin
            err = 1'b1;
        end else if (io_mode) begin
            phys = DATA_BASE + (PA_W'(page) << 16) + IO_WIN_OFF + off_ext;
        end else begin
            unique case (space)
                SP_UNIF: phys = UNIF_BASE + (seg_ext << BLK_LOG2) + off_ext;
                SP_INSN: phys = INSN_BASE + (seg_ext << BLK_LOG2) + off_ext;
                SP_DATA: phys = DATA_BASE + (seg_ext << 16)
                              + (PA_W'(idx) << BLK_LOG2) + off_ext;
                SP_RSVD: err  = 1'b1;
            endcase
        end
        cnt = err ? '0 : clip;
    end
endmodule

// File: rtl/dmap_xlate.sv
module dmap_xlate
    import dmap_pkg::*;
#(
    parameter int LOFF_W   = 20,
    parameter int LEN_W    = 16,
    parameter int PA_W     = 32,
    parameter int BLK_LOG2 = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_waddr,
    input  logic [15:0]       cfg_wdata,
    input  logic [15:0]       cfg_raddr,
    output logic [15:0]       cfg_rdata,
    output logic              cfg_rhit,
    input  logic              xl_req,
    input  logic [LOFF_W-1:0] xl_off,
    input  logic [LEN_W-1:0]  xl_len,
    output logic              xl_vld,
    output logic              xl_err,
    output logic [PA_W-1:0]   xl_phys,
    output logic [LEN_W-1:0]  xl_cnt
);
    typedef struct packed {
        logic             vld;
        logic             err;
        logic [PA_W-1:0]  phys;
        logic [LEN_W-1:0] cnt;
    } res_t;

    map_arr_t         maps;
    logic             c_err;
    logic [PA_W-1:0]  c_phys;
    logic [LEN_W-1:0] c_cnt;
    res_t             res_d, res_q;

    dmap_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_waddr),
        .wdata (cfg_wdata),
        .raddr (cfg_raddr),
        .rdata (cfg_rdata),
        .rhit  (cfg_rhit),
        .maps  (maps)
    );

    dmap_calc #(
        .LOFF_W   (LOFF_W),
        .LEN_W    (LEN_W),
        .PA_W     (PA_W),
        .BLK_LOG2 (BLK_LOG2)
    ) u_calc (
        .maps (maps),
        .off  (xl_off),
        .len  (xl_len),
        .err  (c_err),
        .phys (c_phys),
        .cnt  (c_cnt)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = xl_req;
        if (xl_req) begin
            res_d.err  = c_err;
            res_d.phys = c_phys;
            res_d.cnt  = c_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign xl_vld  = res_q.vld;
    assign xl_err  = res_q.err;
    assign xl_phys = res_q.phys;
    assign xl_cnt  = res_q.cnt;
endmodule

// File: rtl/dmap_xlate_chk.sv
module dmap_xlate_chk #(
    parameter int LOFF_W   = 20,
    parameter int LEN_W    = 16,
    parameter int PA_W     = 32,
    parameter int BLK_LOG2 = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cfg_rdata,
    input logic              cfg_rhit,
    input logic              xl_req,
    input logic [LOFF_W-1:0] xl_off,
    input logic [LEN_W-1:0]  xl_len,
    input logic              xl_vld,
    input logic              xl_err,
    input logic [PA_W-1:0]   xl_phys,
    input logic [LEN_W-1:0]  xl_cnt
);
    localparam int BLK = 1 << BLK_LOG2;
    localparam logic [LOFF_W-1:0] LIMIT = LOFF_W'(4 * BLK);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_vld_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (xl_vld == $past(xl_req)));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(xl_req)) |-> ($stable(xl_phys) && $stable(xl_cnt)));

    assert_oob_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(xl_req && (xl_off >= LIMIT))) |-> (xl_vld && xl_err));

    assert_err_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_vld && xl_err) |-> (xl_cnt == '0 && xl_phys == '0));

    assert_no_cross_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_vld && !xl_err) |-> ((int'(xl_phys[BLK_LOG2-1:0]) + int'(xl_cnt)) <= BLK));

    assert_cnt_le_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && xl_vld && !xl_err) |-> (xl_cnt <= $past(xl_len)));

    assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rhit |-> (cfg_rdata == 16'h0000));
endmodule

bind dmap_xlate dmap_xlate_chk #(
    .LOFF_W   (LOFF_W),
    .LEN_W    (LEN_W),
    .PA_W     (PA_W),
    .BLK_LOG2 (BLK_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .cfg_rhit  (cfg_rhit),
    .xl_req    (xl_req),
    .xl_off    (xl_off),
    .xl_len    (xl_len),
    .xl_vld    (xl_vld),
    .xl_err    (xl_err),
    .xl_phys   (xl_phys),
    .xl_cnt    (xl_cnt)
);

// File: tb/dmap_xlate_bench.sv
module dmap_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_waddr = '0, cfg_wdata = '0, cfg_raddr = '0;
    logic [15:0] cfg_rdata;
    logic        cfg_rhit;
    logic        xl_req = 1'b0;
    logic [19:0] xl_off = '0;
    logic [15:0] xl_len = '0;
    logic        xl_vld, xl_err;
    logic [31:0] xl_phys;
    logic [15:0] xl_cnt;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dmap_xlate u_dmap_xlate (.*);

    typedef struct packed {
        logic [15:0] map;
        logic [19:0] off;
        logic [15:0] len;
        logic [31:0] phys;
        logic [15:0] cnt;
        logic        err;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{16'h0005, 20'h00123, 16'h0004, 32'h0001_4123, 16'h0004, 1'b0}, // R6
        '{16'h1003, 20'h04010, 16'h0008, 32'h0100_C010, 16'h0008, 1'b0}, // R7
        '{16'h2007, 20'h08200, 16'h0002, 32'h0207_8200, 16'h0002, 1'b0}, // R8
        '{16'h3001, 20'h0C000, 16'h0004, 32'h0000_0000, 16'h0000, 1'b1}, // R9
        '{16'hB2C4, 20'h01234, 16'h0010, 32'h0202_D234, 16'h0010, 1'b0}, // R10 R12
        '{16'h8ABC, 20'h07F00, 16'h0200, 32'h020C_FF00, 16'h0100, 1'b0}, // R10 R11
        '{16'h8ABC, 20'h08050, 16'h0001, 32'h0208_C050, 16'h0001, 1'b0}, // R10
        '{16'h0000, 20'h0FFFF, 16'h0002, 32'h0000_3FFF, 16'h0001, 1'b0}, // R11
        '{16'h0000, 20'h10000, 16'h0004, 32'h0000_0000, 16'h0000, 1'b1}, // R5
        '{16'h03FF, 20'h01000, 16'h3000, 32'h00FF_D000, 16'h3000, 1'b0}, // R6 R11
        '{16'h2FFF, 20'h0C004, 16'h0000, 32'h05FF_C004, 16'h0000, 1'b0}  // R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [15:0] a, input logic hit, input logic [15:0] d);
        cfg_raddr = a;
        #1;
        check({tag, " hit"}, 32'(cfg_rhit), 32'(hit));
        check({tag, " data"}, 32'(cfg_rdata), 32'(d));
    endtask

    task automatic xlate(input logic [19:0] off, input logic [15:0] len);
        @(negedge clk);
        xl_req = 1'b1; xl_off = off; xl_len = len;
        @(negedge clk);
        xl_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents
        rd("R1 map0", 16'hFF08, 1'b1, 16'h2000);
        rd("R1 map1", 16'hFF0A, 1'b1, 16'h2000);
        rd("R1 map2", 16'hFF0C, 1'b1, 16'h2000);
        rd("R1 map3", 16'hFF0E, 1'b1, 16'h0000);
        check("R1 vld", 32'(xl_vld), 32'd0);

        // R2 misses and ignored writes
        rd("R2 miss", 16'hFF00, 1'b0, 16'h0000);
        wr(16'hFF06, 16'hFFFF);
        wr(16'hFF09, 16'hFFFF);
        wr(16'hFF10, 16'hFFFF);
        rd("R2 ign0", 16'hFF08, 1'b1, 16'h2000);
        rd("R2 ign1", 16'hFF0A, 1'b1, 16'h2000);
        rd("R2 ign2", 16'hFF0C, 1'b1, 16'h2000);
        rd("R2 ign3", 16'hFF0E, 1'b1, 16'h0000);

        // R2 write lands one edge later
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = 16'hFF0E; cfg_wdata = 16'hBEEF; cfg_raddr = 16'hFF0E;
        #1 check("R2 before edge", 32'(cfg_rdata), 32'h0000);
        @(negedge clk);
        cfg_we = 1'b0;
        #1 check("R2 after edge", 32'(cfg_rdata), 32'hBEEF);

        // R3 alias
        rd("R3 alias read", 16'hFF04, 1'b1, 16'h2000);
        wr(16'hFF04, 16'h1234);
        rd("R3 via main", 16'hFF0C, 1'b1, 16'h1234);
        rd("R3 via alias", 16'hFF04, 1'b1, 16'h1234);

        // R5..R12 table
        for (int i = 0; i < 11; i++) begin
            automatic int ix = (VEC[i].off >= 20'h10000) ? 0 : int'(VEC[i].off[15:14]);
            wr(16'hFF08 + 16'(2 * ix), VEC[i].map);
            xlate(VEC[i].off, VEC[i].len);
            check($sformatf("R5-R12 row %0d vld", i), 32'(xl_vld), 32'd1);
            check($sformatf("R5-R12 row %0d err", i), 32'(xl_err), 32'(VEC[i].err));
            check($sformatf("R5-R12 row %0d phys", i), xl_phys, VEC[i].phys);
            check($sformatf("R5-R12 row %0d cnt", i), 32'(xl_cnt), 32'(VEC[i].cnt));
        end

        // R4 same-cycle write is not seen; result holds between requests
        wr(16'hFF08, 16'h0005);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = 16'hFF08; cfg_wdata = 16'h0006;
        xl_req = 1'b1; xl_off = 20'h00010; xl_len = 16'h0001;
        @(negedge clk);
        cfg_we = 1'b0; xl_req = 1'b0;
        check("R4 old map used", xl_phys, 32'h0001_4010);
        check("R4 vld pulse", 32'(xl_vld), 32'd1);
        @(negedge clk);
        check("R4 vld drops", 32'(xl_vld), 32'd0);
        check("R4 phys holds", xl_phys, 32'h0001_4010);
        xlate(20'h00010, 16'h0001);
        check("R4 new map used", xl_phys, 32'h0001_8010);

        // R1 reset again restores entries
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 rereset map0", 16'hFF08, 1'b1, 16'h2000);
        rd("R1 rereset map3", 16'hFF0E, 1'b1, 16'h0000);
        check("R1 rereset vld", 32'(xl_vld), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule